// File: doc/BRIEF.md
# I2C Master Byte Receiver with Acknowledge Wait

This block is the receive half of an I2C master. It assumes that the bus is already owned: a start condition and the address phase have been issued elsewhere. A host then drives the engine through a small register interface.

After the direction bit selects receive mode, the host performs a read of the data register that it discards. That read starts the clocking of one byte. The engine toggles SCL from a divided system clock, samples SDA in the middle of every high phase, and shifts the bits in MSB first. It then completes a ninth clock on which it drives the acknowledge level that the host chose.

An optional wait mode holds SCL low after the eighth falling edge and raises the interrupt flag there. This gives software time to decide between ACK and NACK before the acknowledge clock runs. Only clearing the flag lets that clock proceed. The flag is also raised when the ninth clock rises, which marks that the byte is complete.

Each later read of the data register returns the finished byte and starts the next one. Once the direction bit has been set to transmit, a command write generates a stop condition and releases the bus.

Top module: `i2c_rx_wait`

## Requirements
- R1: After reset, SCL and SDA are not driven, the control register reads 0x00 and the data register reads 0x00. While the bus-owned bit is 0, SCL is never driven low.
- R2: Address 0 is the data register. A read of it starts one byte, provided all of these hold: the bus-owned bit is 1, the direction bit is 0 and no transfer is in progress. The byte runs eight SCL clocks, and SDA is sampled in the middle of each high phase, MSB first. The completed byte is then returned by a later read of address 0.
- R3: Address 2 is the mode register, with bit 0 as the wait enable and bit 1 as the acknowledge select. With wait enabled, the interrupt flag (address 1, bit 0) becomes 1 on the eighth falling edge of SCL. SCL then stays low with no ninth rising edge for as long as the flag stays 1.
- R4: A write to address 1 with bit 0 = 0 clears the flag. During the wait, this releases SCL so that the ninth (acknowledge) clock runs.
- R5: The flag becomes 1 at the rising edge of the ninth SCL clock. The data register takes the new byte at that same edge and changes at no other time.
- R6: During the ninth clock, SDA is driven low when the acknowledge select is 0 (ACK) and left released when it is 1 (NACK).
- R7: With wait disabled, the flag stays 0 at the eighth falling edge, and the ninth clock follows without a pause.
- R8: In the control register, bit 1 is the direction (1 = transmit), bit 2 is the bus-owned bit and bit 3 is the stop-control bit. Bits 1 and 2 read back and bit 3 reads 0. A stop condition follows a control write with bit 2 = 0 and bit 3 = 0, provided the stored direction bit was already 1, the bus is owned and the engine is idle. In that condition SDA is driven low while SCL is released, and SDA is then released. The bus-owned bit reads 0 afterwards, with neither line driven.
- R9: The same control write made while the stored direction bit is 0 generates no stop condition, and the bus-owned bit stays 1.
- R10: A read of address 0 while a byte is being shifted in returns the previously completed byte.
- R11: Writing 1 to the flag bit never sets the flag. A control write with bit 2 = 1 marks the bus as owned.
- R12: While the bus is owned and no transfer or stop is running, SCL is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| regWr | input | 1 | Host register write strobe |
| regRd | input | 1 | Host register read strobe (a read of address 0 may start a byte) |
| regAddr | input | 2 | Register select: 0 data, 1 control, 2 mode |
| regWdata | input | 4 | Host write data |
| regRdata | output | 8 | Host read data for the selected register (combinational) |
| sdaIn | input | 1 | Sensed level of the SDA line |
| sclDrvLow | output | 1 | Open-drain enable: pull SCL low |
| sdaDrvLow | output | 1 | Open-drain enable: pull SDA low |

## Verification
The bench goes after the wait point. A design that raised the flag only at the ninth clock, or that let SCL rise while the flag was still set, would show a ninth rising edge during the idle window the bench holds open. The bench checks the acknowledge level in both polarities, because an inverted select would NACK a byte that should be acknowledged. It reads the data register in the middle of a byte, where a design that exposed its shift register would return a partial value. It also checks that a stop command is refused unless the direction bit was already set: a design that stopped anyway would drop bus ownership in the middle of a transfer.

// File: rtl/i2c_rx_pkg.sv
package i2c_rx_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_WAIT, ST_ACK_LOW, ST_ACK_HIGH,
    ST_STOP_A, ST_STOP_B, ST_STOP_C
  } rxState_t;

  typedef struct packed {
    logic sampleBit;
    logic commitByte;
  } dpStrobe_t;

  localparam logic [1:0] ADDR_DATA = 2'd0;
  localparam logic [1:0] ADDR_CTRL = 2'd1;
  localparam logic [1:0] ADDR_MODE = 2'd2;

  localparam int CTRL_FLAG = 0;
  localparam int CTRL_DIR  = 1;
  localparam int CTRL_BUSY = 2;
  localparam int CTRL_STOP = 3;
  localparam int MODE_WAIT = 0;
  localparam int MODE_ACK  = 1;
endpackage

// File: rtl/i2c_rx_ctl.sv
module i2c_rx_ctl
  import i2c_rx_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int DATA_W   = 8,
  parameter int WR_W     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            regWr,
  input  logic            regRd,
  input  logic [1:0]      regAddr,
  input  logic [WR_W-1:0] regWdata,
  output logic            irqFlag,
  output logic            dirTx,
  output logic            busBusy,
  output logic            waitEn,
  output logic            ackSel,
  output logic            sclDrvLow,
  output logic            sdaDrvLow,
  output dpStrobe_t       strobe
);
  localparam int CNT_W     = (HALF_CYC > 2) ? $clog2(HALF_CYC) : 1;
  localparam int BIT_W     = $clog2(DATA_W);
  localparam int SAMPLE_AT = HALF_CYC / 2;

  rxState_t         state;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic             phaseEnd;
  logic             ctrlWr;
  logic             modeWr;
  logic             startReq;
  logic             stopReq;

  assign phaseEnd = (cnt == CNT_W'(HALF_CYC - 1));
  assign ctrlWr   = regWr && (regAddr == ADDR_CTRL);
  assign modeWr   = regWr && (regAddr == ADDR_MODE);
  assign startReq = regRd && (regAddr == ADDR_DATA) && (state == ST_IDLE)
                    && busBusy && !dirTx;
  assign stopReq  = ctrlWr && !regWdata[CTRL_BUSY] && !regWdata[CTRL_STOP]
                    && dirTx && busBusy && (state == ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitCnt  <= '0;
      irqFlag <= 1'b0;
      dirTx   <= 1'b0;
      busBusy <= 1'b0;
      waitEn  <= 1'b0;
      ackSel  <= 1'b0;
    end else begin
      // host side first; engine events below take priority
      if (ctrlWr) begin
        if (!regWdata[CTRL_FLAG]) irqFlag <= 1'b0;
        dirTx <= regWdata[CTRL_DIR];
        if (regWdata[CTRL_BUSY]) busBusy <= 1'b1;
      end
      if (modeWr) begin
        waitEn <= regWdata[MODE_WAIT];
        ackSel <= regWdata[MODE_ACK];
      end

      if (state == ST_IDLE || state == ST_WAIT) cnt <= '0;
      else cnt <= phaseEnd ? '0 : cnt + CNT_W'(1);

      unique case (state)
        ST_IDLE: begin
          bitCnt <= '0;
          if (startReq)     state <= ST_LOW;
          else if (stopReq) state <= ST_STOP_A;
        end
        ST_LOW: if (phaseEnd) state <= ST_HIGH;
        ST_HIGH: if (phaseEnd) begin
          if (bitCnt == BIT_W'(DATA_W - 1)) begin
            if (waitEn) begin
              state   <= ST_WAIT;
              irqFlag <= 1'b1;
            end else begin
              state <= ST_ACK_LOW;
            end
          end else begin
            bitCnt <= bitCnt + BIT_W'(1);
            state  <= ST_LOW;
          end
        end
        ST_WAIT: if (!irqFlag) state <= ST_ACK_LOW;
        ST_ACK_LOW: if (phaseEnd) begin
          state   <= ST_ACK_HIGH;
          irqFlag <= 1'b1;
        end
        ST_ACK_HIGH: if (phaseEnd) state <= ST_IDLE;
        ST_STOP_A:   if (phaseEnd) state <= ST_STOP_B;
        ST_STOP_B:   if (phaseEnd) state <= ST_STOP_C;
        ST_STOP_C: if (phaseEnd) begin
          state   <= ST_IDLE;
          busBusy <= 1'b0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state)
      ST_IDLE:                          sclDrvLow = busBusy;
      ST_LOW, ST_WAIT, ST_ACK_LOW,
      ST_STOP_A:                        sclDrvLow = 1'b1;
      default:                          sclDrvLow = 1'b0;
    endcase
    sdaDrvLow = (((state == ST_ACK_LOW) || (state == ST_ACK_HIGH)) && !ackSel)
                || (state == ST_STOP_A) || (state == ST_STOP_B);
    strobe.sampleBit  = (state == ST_HIGH) && (cnt == CNT_W'(SAMPLE_AT));
    strobe.commitByte = (state == ST_ACK_LOW) && phaseEnd;
  end
endmodule

// File: rtl/i2c_rx_dp.sv
module i2c_rx_dp
  import i2c_rx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  dpStrobe_t         strobe,
  input  logic              sdaIn,
  output logic [DATA_W-1:0] rxByte
);
  logic [DATA_W-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (rst) begin
      shiftReg <= '0;
      rxByte   <= '0;
    end else begin
      if (strobe.sampleBit)  shiftReg <= {shiftReg[DATA_W-2:0], sdaIn};
      if (strobe.commitByte) rxByte   <= shiftReg;
    end
  end
endmodule

// File: rtl/i2c_rx_wait.sv
module i2c_rx_wait
  import i2c_rx_pkg::*;
#(
  parameter int HALF_CYC = 4,
  parameter int DATA_W   = 8,
  parameter int WR_W     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              regWr,
  input  logic              regRd,
  input  logic [1:0]        regAddr,
  input  logic [WR_W-1:0]   regWdata,
  output logic [DATA_W-1:0] regRdata,
  input  logic              sdaIn,
  output logic              sclDrvLow,
  output logic              sdaDrvLow
);
  dpStrobe_t         strobe;
  logic              irqFlag;
  logic              dirTx;
  logic              busBusy;
  logic              waitEn;
  logic              ackSel;
  logic [DATA_W-1:0] rxByte;

  i2c_rx_ctl #(.HALF_CYC(HALF_CYC), .DATA_W(DATA_W), .WR_W(WR_W)) i_ctl (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .irqFlag(irqFlag), .dirTx(dirTx), .busBusy(busBusy),
    .waitEn(waitEn), .ackSel(ackSel), .sclDrvLow(sclDrvLow),
    .sdaDrvLow(sdaDrvLow), .strobe(strobe)
  );

  i2c_rx_dp #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rst(rst), .strobe(strobe), .sdaIn(sdaIn), .rxByte(rxByte)
  );

  always_comb begin
    regRdata = '0;
    unique case (regAddr)
      ADDR_DATA: regRdata = rxByte;
      ADDR_CTRL: begin
        regRdata[CTRL_FLAG] = irqFlag;
        regRdata[CTRL_DIR]  = dirTx;
        regRdata[CTRL_BUSY] = busBusy;
      end
      ADDR_MODE: begin
        regRdata[MODE_WAIT] = waitEn;
        regRdata[MODE_ACK]  = ackSel;
      end
      default: regRdata = '0;
    endcase
  end
endmodule

// File: rtl/i2c_rx_chk.sv
module i2c_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              sclDrvLow,
  input logic              sdaDrvLow,
  input logic              irqFlag,
  input logic              busBusy,
  input logic [DATA_W-1:0] rxByte
);
  // R5
  rx_commit_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(rxByte) |-> $rose(irqFlag));

  // R8
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busBusy) |-> (!sclDrvLow && !sdaDrvLow));

  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    !busBusy |-> !sclDrvLow);

  // R3
  flag_on_edge_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irqFlag) |-> !$stable(sclDrvLow));
endmodule

bind i2c_rx_wait i2c_rx_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow),
  .irqFlag(irqFlag), .busBusy(busBusy), .rxByte(rxByte)
);

// File: tb/test_i2c_rx_wait.sv
module test_i2c_rx_wait;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       regWr = 1'b0;
  logic       regRd = 1'b0;
  logic [1:0] regAddr = 2'd0;
  logic [3:0] regWdata = 4'd0;
  logic [7:0] regRdata;
  logic       sclDrvLow;
  logic       sdaDrvLow;
  logic       sdaIn;
  logic       sclLine;

  int   errors = 0;
  int   checks = 0;
  int   fallCnt = 0;
  int   riseCnt = 0;
  int   slvIdx = 8;
  logic [7:0] slvByte = 8'h00;
  logic slvBit;
  logic sdaAckLow = 1'b0;
  logic stopSeen = 1'b0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  i2c_rx_wait i_i2c_rx_wait (
    .clk(clk), .rst(rst), .regWr(regWr), .regRd(regRd), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .sdaIn(sdaIn),
    .sclDrvLow(sclDrvLow), .sdaDrvLow(sdaDrvLow)
  );

  assign sclLine = ~sclDrvLow;
  assign slvBit  = (slvIdx < 8) ? slvByte[7 - slvIdx] : 1'b1;
  assign sdaIn   = ~sdaDrvLow & slvBit;

  always @(negedge sclLine) begin
    fallCnt = fallCnt + 1;
    if (slvIdx < 8) slvIdx = slvIdx + 1;
  end
  always @(posedge sclLine) begin
    if (riseCnt == 8) sdaAckLow = sdaDrvLow;
    riseCnt = riseCnt + 1;
  end
  always @(posedge sdaIn) if (sclLine) stopSeen = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdata;
    @(negedge clk);
    regRd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [3:0] v);
    @(negedge clk);
    regAddr = a; regWdata = v; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic waitFalls(input int n);
    for (int t = 0; t < 3000 && fallCnt < n; t++) @(negedge clk);
  endtask

  task automatic waitRises(input int n);
    for (int t = 0; t < 3000 && riseCnt < n; t++) @(negedge clk);
  endtask

  task automatic armSlave(input logic [7:0] b);
    slvByte = b; slvIdx = 0; fallCnt = 0; riseCnt = 0; sdaAckLow = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] d;
    chk(!sclDrvLow && !sdaDrvLow, "R1 lines released", {sclDrvLow, sdaDrvLow}, 0);
    rd(2'd1, d);
    chk(d == 8'h00, "R1 control reset", d, 8'h00);
    rd(2'd0, d);
    chk(d == 8'h00, "R1 data reset", d, 8'h00);
    repeat (5) @(negedge clk);
    chk(!sclDrvLow, "R1 no SCL drive when not owned", sclDrvLow, 0);
  endtask

  task automatic t_own();
    logic [7:0] d;
    wr(2'd1, 4'b1101);               // flag=1 write, busy=1, stop-ctl=1
    rd(2'd1, d);
    chk(d == 8'h04, "R11 flag not set by write, busy set", d, 8'h04);
    repeat (6) @(negedge clk);
    chk(sclDrvLow && !sdaDrvLow, "R12 SCL held low when owned and idle",
        {sclDrvLow, sdaDrvLow}, 2'b10);
  endtask

  task automatic t_waitByte();
    logic [7:0] d;
    wr(2'd2, 4'b0001);               // wait on, ACK
    armSlave(8'hA5);
    rd(2'd0, d);                     // dummy read starts the byte
    waitFalls(8);
    rd(2'd1, d);
    chk(d[0] == 1'b1, "R3 flag at 8th falling edge", d[0], 1);
    repeat (20) @(negedge clk);
    chk(!sclLine && riseCnt == 8, "R3 SCL held low in wait", riseCnt, 8);
    wr(2'd1, 4'b1100);               // clear flag, keep busy
    waitRises(9);
    chk(riseCnt == 9, "R4 ninth clock after flag clear", riseCnt, 9);
    rd(2'd1, d);
    chk(d[0] == 1'b1, "R5 flag at 9th rising edge", d[0], 1);
    chk(sdaAckLow == 1'b1, "R6 ACK drives SDA low", sdaAckLow, 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_noWaitByte();
    logic [7:0] d;
    wr(2'd1, 4'b1100);
    wr(2'd2, 4'b0010);               // wait off, NACK
    armSlave(8'h3C);
    rd(2'd0, d);
    chk(d == 8'hA5, "R2 first byte MSB first", d, 8'hA5);
    waitFalls(3);
    rd(2'd0, d);
    chk(d == 8'hA5, "R10 mid-byte read returns prior byte", d, 8'hA5);
    waitFalls(8);
    rd(2'd1, d);
    chk(d[0] == 1'b0, "R7 no flag at 8th fall without wait", d[0], 0);
    waitRises(9);
    rd(2'd1, d);
    chk(d[0] == 1'b1 && riseCnt == 9, "R7 ninth clock runs on", riseCnt, 9);
    chk(sdaAckLow == 1'b0, "R6 NACK leaves SDA released", sdaAckLow, 0);
    repeat (8) @(negedge clk);
  endtask

  task automatic t_stopIgnored();
    logic [7:0] d;
    wr(2'd1, 4'b0000);               // direction still receive
    repeat (20) @(negedge clk);
    rd(2'd1, d);
    chk(d[2] == 1'b1, "R9 stop refused in receive direction", d[2], 1);
    chk(sclDrvLow, "R9 SCL still held", sclDrvLow, 1);
  endtask

  task automatic t_stop();
    logic [7:0] d;
    wr(2'd1, 4'b0110);               // direction transmit, busy kept
    rd(2'd0, d);
    chk(d == 8'h3C, "R2 final byte read", d, 8'h3C);
    stopSeen = 1'b0;
    wr(2'd1, 4'b0010);               // busy=0, stop-ctl=0
    for (int t = 0; t < 100; t++) begin
      rd(2'd1, d);
      if (d[2] == 1'b0) break;
    end
    chk(d[2] == 1'b0, "R8 bus-owned clears after stop", d[2], 0);
    chk(stopSeen, "R8 SDA rises while SCL high", stopSeen, 1);
    chk(!sclDrvLow && !sdaDrvLow, "R8 lines released after stop",
        {sclDrvLow, sdaDrvLow}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_own();
    t_waitByte();
    t_noWaitByte();
    t_stopIgnored();
    t_stop();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule